// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Framing-Error Flag

This block is the receive side of a classic byte-oriented serial port, together with its control/status register. It watches a serial input line, finds start bits, and reassembles a frame. A frame carries eight data bits, least significant first. In the nine-bit modes a ninth bit follows, and every frame ends with one stop bit. It raises a receive flag when a byte is ready and holds the byte on a parallel output. It can also record a missing stop bit in a sticky error flag.

Bit timing comes from an external 16x oversampling tick. The line passes through a two-flop synchronizer. Each bit is decided by a majority vote over three samples taken around mid-bit.

A select input decides the meaning of register bit 7. Reads and writes of that bit reach either the upper mode bit or the framing-error flag. The same select input moves the point in a nine-bit frame where the receive flag is raised.

The received byte is a plain holding output. The receive flag acts as its valid indication, and software clearing that flag acts as the acknowledge. A new frame overwrites the byte whether or not the flag was cleared, so there is no back-pressure on the line side.

Top module: `serrx_top`

## Requirements
- R1: After reset the control register reads 00h (with either select value) and the received-byte output is 00h.
- R2: The register layout, from bit 7 down to bit 0, is: upper mode bit or error flag, lower mode bit, address-filter enable (stored only), receive enable, transmit ninth bit, received ninth bit, transmit flag, receive flag.
- R3: The two mode bits {bit7 mode bit, bit6} select the mode as follows:
  - 00 is the shift mode, which receives nothing.
  - 01 is the 8-bit mode.
  - 10 and 11 are the 9-bit modes.
- R4: When a frame completes, the received-byte output holds the data bits, with the first bit on the line in bit 0.
- R5: In the 9-bit modes, the received-ninth-bit field takes the ninth bit of the frame when the receive flag is raised.
- R6: In the 8-bit mode the receive flag is raised during the stop bit for either select value. In the 9-bit modes it is raised during the stop bit when the select input is 1, and during the ninth bit when it is 0.
- R7: When the select input is 1 and the stop bit is sampled as 0, the framing-error flag is set. When the select input is 0, the flag is never set.
- R8: The framing-error flag is sticky. A later frame with a valid stop bit does not clear it, and only a software write of 0 to bit 7 while the select input is 1 clears it.
- R9: With the select input at 1, bit 7 reads and writes reach the error flag and the stored upper mode bit is untouched. With the select input at 0, bit 7 reaches the mode bit.
- R10: Software writes can only clear the receive flag and the error flag; writing 1 to them has no effect. A hardware set in the same cycle as a software clear leaves the flag set.
- R11: Nothing is received while receive enable is 0 or the mode is the shift mode. Clearing receive enable mid-frame sends the receiver back to idle.
- R12: A start bit is accepted only if the majority of samples at ticks 7, 8 and 9 after the falling edge is low. A shorter low pulse returns the receiver to idle without raising any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse, 16 per bit time |
| rxd | input | 1 | Asynchronous serial input, idle high |
| fe_sel | input | 1 | Bit-7 select: 1 = error flag, 0 = mode bit |
| scon_wr | input | 1 | Register write strobe |
| scon_wdata | input | 8 | Register write data |
| scon_rdata | output | 8 | Register read data |
| rx_byte | output | 8 | Last received data byte |

## Verification
The assertions assume three things about the inputs:
- `bit_tick` is a single-cycle pulse with at least one idle cycle between pulses.
- Each serial bit on `rxd` stays stable for the 16 ticks of its bit time.
- The select input and the mode bits change only while the line is idle between frames.

The bench meets these conditions as follows. It generates one tick every four clocks. It holds each bit for exactly 64 clocks. It rewrites the register and moves the select input only after the line has been idle for two bit times. A short low pulse is the only deliberate break in the bit timing, and it is used for the start-validation check.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_NINTH,
    RX_STOP
  } rx_state_e;

  // Hardware events from the sequencer to the register file.
  typedef struct packed {
    logic ri_set;
    logic fe_set;
    logic rb8_load;
    logic rb8_val;
  } rx_event_t;

  // Mode pair {m_hi, m_lo}: 00 shift (no receive), 01 8-bit, 1x 9-bit.
  function automatic logic mode_receives(input logic m_hi, input logic m_lo);
    return m_hi | m_lo;
  endfunction

  function automatic logic mode_nine_bit(input logic m_hi);
    return m_hi;
  endfunction

endpackage

// File: rtl/serrx_sync.sv
module serrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n) q[0] <= 1'b1;
    else        q[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) q[g] <= 1'b1;
      else        q[g] <= q[g-1];
    end
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/serrx_vote.sv
module serrx_vote #(
  parameter int OVS = 16,
  localparam int CW = $clog2(OVS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] cnt,
  input  logic          rx,
  output logic          bit_val
);
  localparam logic [CW-1:0] SAMP_A = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] SAMP_B = CW'(OVS / 2);

  logic s_a, s_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_a <= 1'b1;
      s_b <= 1'b1;
    end else if (tick) begin
      if (cnt == SAMP_A) s_a <= rx;
      if (cnt == SAMP_B) s_b <= rx;
    end
  end

  // Third sample is the live line at the decision tick.
  assign bit_val = (s_a & s_b) | (s_a & rx) | (s_b & rx);
endmodule

// File: rtl/serrx_fsm.sv
module serrx_fsm
  import serrx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx,
  input  logic              rx_en,
  input  logic              nine_bit,
  input  logic              fe_sel,
  output rx_event_t         evt,
  output logic [DATA_W-1:0] data_out
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DATA_W);
  localparam logic [CW-1:0] DECIDE = CW'(OVS / 2 + 1);
  localparam logic [CW-1:0] LAST   = CW'(OVS - 1);
  localparam logic [IW-1:0] TOP_BIT = IW'(DATA_W - 1);

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     bit_idx;
  logic [DATA_W-1:0] shreg;
  logic              nine_q;
  logic              vote;

  serrx_vote #(.OVS(OVS)) u_vote (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .rx(rx), .bit_val(vote)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      nine_q  <= 1'b0;
    end else if (!rx_en) begin
      state <= RX_IDLE;
      cnt   <= '0;
    end else if (tick) begin
      unique case (state)
        RX_IDLE: begin
          if (!rx) begin
            state <= RX_START;
            cnt   <= CW'(1);
          end
        end
        RX_START: begin
          if (cnt == DECIDE && vote) begin
            state <= RX_IDLE;
            cnt   <= '0;
          end else if (cnt == LAST) begin
            state   <= RX_DATA;
            cnt     <= '0;
            bit_idx <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt == DECIDE) shreg <= {vote, shreg[DATA_W-1:1]};
          if (cnt == LAST) begin
            cnt <= '0;
            if (bit_idx == TOP_BIT) state <= nine_bit ? RX_NINTH : RX_STOP;
            else                    bit_idx <= bit_idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_NINTH: begin
          if (cnt == DECIDE) nine_q <= vote;
          if (cnt == LAST) begin
            state <= RX_STOP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt == DECIDE) begin
            state <= RX_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= RX_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  logic fire_nine, fire_stop;
  assign fire_nine = rx_en && tick && (state == RX_NINTH) && (cnt == DECIDE);
  assign fire_stop = rx_en && tick && (state == RX_STOP)  && (cnt == DECIDE);

  always_comb begin
    evt.ri_set   = (fire_nine && !fe_sel) || (fire_stop && (!nine_bit || fe_sel));
    evt.fe_set   = fire_stop && fe_sel && !vote;
    evt.rb8_load = evt.ri_set && nine_bit;
    evt.rb8_val  = fire_nine ? vote : nine_q;
  end

  assign data_out = shreg;

  AST_REN_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> state == RX_IDLE);                                  // R11
  AST_NINTH_RI_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    evt.ri_set && state == RX_NINTH |-> !fe_sel);                  // R6
  AST_START_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    state == RX_IDLE && rx_en && tick && !rx |=> state == RX_START); // R12
endmodule

// File: rtl/serrx_ctrl.sv
module serrx_ctrl
  import serrx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       fe_sel,
  input  rx_event_t  evt,
  output logic [7:0] rdata,
  output logic       m_hi,
  output logic       m_lo,
  output logic       ren
);
  logic addr_en, tx9, rx9, tx_flag, ri, fe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_hi <= 1'b0; m_lo <= 1'b0; addr_en <= 1'b0; ren <= 1'b0;
      tx9  <= 1'b0; rx9  <= 1'b0; tx_flag <= 1'b0; ri  <= 1'b0;
      fe   <= 1'b0;
    end else begin
      if (wr) begin
        if (!fe_sel)        m_hi <= wdata[7];
        else if (!wdata[7]) fe   <= 1'b0;
        m_lo    <= wdata[6];
        addr_en <= wdata[5];
        ren     <= wdata[4];
        tx9     <= wdata[3];
        rx9     <= wdata[2];
        tx_flag <= wdata[1];
        if (!wdata[0]) ri <= 1'b0;
      end
      // Hardware sets come last so they win over a same-cycle clear.
      if (evt.fe_set)   fe  <= 1'b1;
      if (evt.ri_set)   ri  <= 1'b1;
      if (evt.rb8_load) rx9 <= evt.rb8_val;
    end
  end

  assign rdata = {fe_sel ? fe : m_hi, m_lo, addr_en, ren, tx9, rx9, tx_flag, ri};

  AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fe && !(wr && fe_sel && !wdata[7]) |=> fe);                     // R8
  AST_FE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    evt.fe_set |-> fe_sel);                                         // R7
  AST_RI_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !ri && !evt.ri_set |=> !ri);                                    // R10
  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt.ri_set |=> ri);                                             // R10
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wr && fe_sel |=> m_hi == $past(m_hi));                          // R9
endmodule

// File: rtl/serrx_top.sv
module serrx_top
  import serrx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       rxd,
  input  logic       fe_sel,
  input  logic       scon_wr,
  input  logic [7:0] scon_wdata,
  output logic [7:0] scon_rdata,
  output logic [7:0] rx_byte
);
  localparam int DATA_W = 8;

  logic              rx_s;
  logic              m_hi, m_lo, ren;
  rx_event_t         evt;
  logic [DATA_W-1:0] shifted;

  serrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
  );

  serrx_fsm #(.OVS(OVS), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .rx(rx_s),
    .rx_en(ren && mode_receives(m_hi, m_lo)),
    .nine_bit(mode_nine_bit(m_hi)), .fe_sel(fe_sel),
    .evt(evt), .data_out(shifted)
  );

  serrx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(scon_wr), .wdata(scon_wdata),
    .fe_sel(fe_sel), .evt(evt), .rdata(scon_rdata),
    .m_hi(m_hi), .m_lo(m_lo), .ren(ren)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          rx_byte <= '0;
    else if (evt.ri_set) rx_byte <= shifted;
  end

  AST_BYTE_ON_RI: assert property (@(posedge clk) disable iff (!rst_n)
    !evt.ri_set |=> $stable(rx_byte));                              // R4
endmodule

// File: tb/tb_serrx_top.sv
module tb_serrx_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick;
  logic       rxd = 1'b1;
  logic       fe_sel = 1'b0;
  logic       scon_wr = 1'b0;
  logic [7:0] scon_wdata = 8'h00;
  logic [7:0] scon_rdata;
  logic [7:0] rx_byte;
  logic [1:0] tcnt;
  int vectors = 0;
  int misses  = 0;
  bit done = 0;

  localparam int BIT_CLKS = 64;

  serrx_top dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rxd(rxd), .fe_sel(fe_sel),
    .scon_wr(scon_wr), .scon_wdata(scon_wdata), .scon_rdata(scon_rdata),
    .rx_byte(rx_byte)
  );

  always #4 clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rst_n) tcnt <= 2'd0;
    else        tcnt <= tcnt + 2'd1;
  end
  assign bit_tick = rst_n && (tcnt == 2'd0);

  task automatic chk(input logic [8:0] act, input logic [8:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_scon(input logic [7:0] v, input logic sel);
    @(negedge clk);
    fe_sel = sel; scon_wr = 1'b1; scon_wdata = v;
    @(negedge clk);
    scon_wr = 1'b0;
  endtask

  task automatic rd_scon(input logic sel, output logic [7:0] v);
    @(negedge clk);
    fe_sel = sel;
    #1 v = scon_rdata;
  endtask

  task automatic hold_bit(input logic b, input int clks);
    rxd = b;
    repeat (clks) @(posedge clk);
    #1;
  endtask

  // Clear flags, set mode and enable, then apply select.
  task automatic setup(input logic [1:0] m, input logic ren, input logic sel);
    wr_scon(8'h00, 1'b1);
    wr_scon({m, 1'b0, ren, 4'b0000}, 1'b0);
    @(negedge clk); fe_sel = sel;
  endtask

  // Sends a frame; in 9-bit frames checks RI late in the ninth bit.
  task automatic send(input logic [7:0] d, input logic has9, input logic b9,
                      input logic stopv, input logic sel);
    hold_bit(1'b0, BIT_CLKS);
    for (int i = 0; i < 8; i++) hold_bit(d[i], BIT_CLKS);
    if (has9) begin
      hold_bit(b9, BIT_CLKS - 2);
      chk({8'h0, scon_rdata[0]}, {8'h0, !sel}, "R6 RI at ninth bit");
      hold_bit(b9, 2);
    end
    hold_bit(stopv, BIT_CLKS);
    hold_bit(1'b1, 2 * BIT_CLKS);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset values, read through both bit-7 views
    rd_scon(1'b0, v); chk({1'b0, v}, 9'h000, "R1 reset scon sel0");
    rd_scon(1'b1, v); chk({1'b0, v}, 9'h000, "R1 reset scon sel1");
    chk({1'b0, rx_byte}, 9'h000, "R1 reset rx_byte");

    // Sweep: modes 8-bit/9-bit x select x stop value x data
    for (int m = 1; m < 4; m++)
      for (int s = 0; s < 2; s++)
        for (int st = 0; st < 2; st++)
          for (int k = 0; k < 4; k++) begin
            logic [7:0] d;
            logic has9, b9, sel, stopv;
            d = 8'(k * 83 + m * 29 + s * 7 + st);
            has9 = (m >= 2);
            b9 = ^d;
            sel = s[0]; stopv = st[0];
            setup(2'(m), 1'b1, sel);
            send(d, has9, b9, stopv, sel);
            chk({8'h0, scon_rdata[0]}, 9'h001, "R6 RI after frame");
            chk({1'b0, rx_byte}, {1'b0, d}, "R4 data byte");
            // R2 R5: received ninth bit in bit 2; stays 0 in 8-bit mode
            chk({8'h0, scon_rdata[2]}, {8'h0, has9 ? b9 : 1'b0}, "R5 ninth bit");
            rd_scon(1'b1, v);
            chk({8'h0, v[7]}, {8'h0, sel && !stopv}, "R7 framing error");
            rd_scon(1'b0, v);
            chk({8'h0, v[7]}, {8'h0, 1'(m >> 1)}, "R3 R9 mode bit view");
            @(negedge clk); fe_sel = sel;
          end

    // R8: error is sticky across a good frame, cleared by a 0 write
    setup(2'b01, 1'b1, 1'b1);
    send(8'h3C, 1'b0, 1'b0, 1'b0, 1'b1);
    wr_scon(8'hD0, 1'b1);                // bit7=1 keeps error, RI cleared
    send(8'hC3, 1'b0, 1'b0, 1'b1, 1'b1);
    rd_scon(1'b1, v);
    chk({1'b0, v}, 9'h0D1, "R8 sticky error after valid stop");
    wr_scon(8'h50, 1'b1);
    rd_scon(1'b1, v);
    chk({8'h0, v[7]}, 9'h000, "R8 error cleared by write");

    // R10: writing 1 to the receive and error flags sets nothing
    wr_scon(8'h91, 1'b1);
    rd_scon(1'b1, v);
    chk({8'h0, v[7], v[0]}, 9'h000, "R10 write-one no set");

    // R9: bit-7 writes under select 1 leave the mode bit alone
    wr_scon(8'h90, 1'b0);
    wr_scon(8'h10, 1'b1);
    rd_scon(1'b0, v);
    chk({8'h0, v[7]}, 9'h001, "R9 mode bit untouched");

    // R11: receive disabled, then the shift mode
    setup(2'b01, 1'b0, 1'b0);
    send(8'h77, 1'b0, 1'b0, 1'b1, 1'b0);
    chk({8'h0, scon_rdata[0]}, 9'h000, "R11 REN=0 no receive");
    chk({1'b0, rx_byte}, 9'h0C3, "R11 byte unchanged ren0");
    setup(2'b00, 1'b1, 1'b0);
    send(8'h77, 1'b0, 1'b0, 1'b1, 1'b0);
    chk({8'h0, scon_rdata[0]}, 9'h000, "R11 shift mode no receive");

    // R12: a two-tick low pulse is rejected, then a real frame is taken
    setup(2'b01, 1'b1, 1'b0);
    hold_bit(1'b0, 8);
    hold_bit(1'b1, 4 * BIT_CLKS);
    chk({8'h0, scon_rdata[0]}, 9'h000, "R12 glitch rejected");
    send(8'h96, 1'b0, 1'b0, 1'b1, 1'b0);
    chk({1'b0, rx_byte}, 9'h096, "R12 frame after glitch");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule